// File: doc/BRIEF.md
# DMA Request Channel Multiplexer

This block sits between a set of peripheral DMA request lines and a smaller set of DMA engine channels. Each channel owns one byte-wide configuration register on a simple register bus. That register picks which source feeds the channel, switches the channel on or off, and on the low channels can make forwarding wait for a periodic trigger pulse. The block drives one request line per channel. It returns the engine's per-channel acknowledge to whichever source that channel currently selects.

Each channel is in one of three modes. When off, it never requests. When transparent, it follows its selected source. When trigger-gated, a rising edge on the channel's trigger input arms the channel. The armed channel forwards the source request until the engine acknowledges, so each trigger pulse allows at most one transfer. Requests, acknowledges and read data all leave the block through registers, so each has one clock of latency.

Top module: `dmamux_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every configuration register reads 0x00, every `ch_req` and `src_ack` bit is 0 and `bus_rdata` is 0x00.
- R2: The register of channel c sits at byte address c. Bit 7 is enable, bit 6 is trigger enable and bits 5:0 are the source number. A write with `bus_we` high takes effect at the next clock edge. `bus_rdata` shows, one cycle later, the register at the address presented in the previous cycle, as it was before that cycle's write. Addresses at or above the channel count read 0x00, and writes to them change nothing.
- R3: When a channel's enable bit is 0, its `ch_req` is 0 whatever the trigger and source fields hold.
- R4: When enable is 1 and trigger enable is 0, `ch_req[c]` equals, one cycle later, `src_req` of the selected source.
- R5: When enable and trigger enable are both 1, a rising edge on `trig_in[c]` arms the channel. While armed, the selected source request is forwarded as in R4. A high `ch_ack[c]` disarms the channel at the next edge unless a new rising edge arrives in the same cycle. Before the channel is armed, `ch_req[c]` is 0.
- R6: On channels at or above the trigger channel count (8), bit 6 reads back 0, writes to it are dropped, and the channel behaves as in R4 when enabled.
- R7: A source number at or above the source count (59..63) selects nothing. `ch_req` stays 0 and no acknowledge is returned.
- R8: `src_ack[s]` is high one cycle after some enabled channel that selects source s had `ch_ack` high, and is 0 otherwise.
- R9: A write to a channel's register clears that channel's arm at the same edge, even when the written value is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address (read and write) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data |
| src_req | input | 59 | Request line from each peripheral source |
| src_ack | output | 59 | Acknowledge back to each source |
| trig_in | input | 8 | Periodic trigger input for each of the low channels |
| ch_req | output | 32 | Request to each DMA channel |
| ch_ack | input | 32 | Acknowledge from each DMA channel |

## Verification
The bench builds the block with its default parameters: 32 channels, 59 sources and 8 trigger-capable channels. This puts the unused source numbers 59..63 inside the 6-bit select field, so R7 can be exercised. It also places the trigger boundary between channels 7 and 8, so R6 can be tested on both sides. The 8-bit address bus reaches beyond the 32 registers, which covers the unmapped-address case of R2. Directed sequences cover trigger arming, disarming on acknowledge, and disarming on a register rewrite. A long random phase then drives many channels onto the same source, so that acknowledges from several channels merge onto one source.

// File: rtl/dmamux_pkg.sv
package dmamux_pkg;

  // Register layout: enable in the top bit, trigger enable below it,
  // source number in the low bits.
  localparam int CFG_W    = 8;
  localparam int SEL_W    = 6;
  localparam int EN_BIT   = 7;
  localparam int TRIG_BIT = 6;
  localparam int SEL_SPAN = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             trig;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;

endpackage

// File: rtl/dmamux_cfg_regs.sv
module dmamux_cfg_regs
  import dmamux_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int TRIG_CH = 8,
  parameter int ADDR_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CFG_W-1:0]      bus_wdata,
  output logic [CFG_W-1:0]      bus_rdata,
  output chan_cfg_t [NUM_CH-1:0] cfg_o,
  output logic [NUM_CH-1:0]     wr_hit
);

  chan_cfg_t [NUM_CH-1:0] cfg_q;
  chan_cfg_t              rd_mux;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign wr_hit[c] = bus_we && (bus_addr == ADDR_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c].en  <= 1'b0;
        cfg_q[c].sel <= '0;
      end else if (wr_hit[c]) begin
        cfg_q[c].en  <= bus_wdata[EN_BIT];
        cfg_q[c].sel <= bus_wdata[SEL_W-1:0];
      end
    end

    if (c < TRIG_CH) begin : g_trig_bit
      always_ff @(posedge clk) begin
        if (rst)
          cfg_q[c].trig <= 1'b0;
        else if (wr_hit[c])
          cfg_q[c].trig <= bus_wdata[TRIG_BIT];
      end
    end else begin : g_no_trig_bit
      assign cfg_q[c].trig = 1'b0;
    end
  end

  // Read port: the address decodes to one register, and an unmapped address reads zero.
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == ADDR_W'(c))
        rd_mux = cfg_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else
      bus_rdata <= rd_mux;
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/dmamux_trig_gate.sv
module dmamux_trig_gate
  import dmamux_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int TRIG_CH = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TRIG_CH-1:0]     trig_in,
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  input  logic [NUM_CH-1:0]      wr_hit,
  input  logic [NUM_CH-1:0]      ch_ack,
  output logic [NUM_CH-1:0]      gate_open,
  output logic [NUM_CH-1:0]      armed_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    if (c < TRIG_CH) begin : g_gated
      logic trig_q;
      logic armed_q;
      logic rise;

      assign rise = trig_in[c] && !trig_q;

      always_ff @(posedge clk) begin
        if (rst)
          trig_q <= 1'b0;
        else
          trig_q <= trig_in[c];
      end

      // A register write clears the arm first, a new pulse sets it next,
      // and an acknowledge clears it last.
      always_ff @(posedge clk) begin
        if (rst)
          armed_q <= 1'b0;
        else if (wr_hit[c])
          armed_q <= 1'b0;
        else if (rise && cfg[c].en && cfg[c].trig)
          armed_q <= 1'b1;
        else if (ch_ack[c])
          armed_q <= 1'b0;
      end

      assign gate_open[c] = !cfg[c].trig || armed_q;
      assign armed_o[c]   = armed_q;
    end else begin : g_plain
      assign gate_open[c] = 1'b1;
      assign armed_o[c]   = 1'b0;
    end
  end

endmodule

// File: rtl/dmamux_route.sv
module dmamux_route
  import dmamux_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 59
) (
  input  logic                   clk,
  input  logic                   rst,
  input  chan_cfg_t [NUM_CH-1:0] cfg,
  input  logic [NUM_CH-1:0]      gate_open,
  input  logic [NUM_SRC-1:0]     src_req,
  input  logic [NUM_CH-1:0]      ch_ack,
  output logic [NUM_CH-1:0]      ch_req,
  output logic [NUM_SRC-1:0]     src_ack
);

  logic [SEL_SPAN-1:0] src_pad;
  logic [NUM_CH-1:0]   req_nxt;
  logic [NUM_SRC-1:0]  ack_nxt;

  // Unused source numbers see a constant zero.
  always_comb begin
    src_pad                = '0;
    src_pad[NUM_SRC-1:0]   = src_req;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    assign req_nxt[c] = cfg[c].en && gate_open[c] && src_pad[cfg[c].sel];
  end

  always_comb begin
    ack_nxt = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (cfg[c].en && ch_ack[c] && (cfg[c].sel == SEL_W'(s)))
          ack_nxt[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_req  <= '0;
      src_ack <= '0;
    end else begin
      ch_req  <= req_nxt;
      src_ack <= ack_nxt;
    end
  end

endmodule

// File: rtl/dmamux_top.sv
module dmamux_top
  import dmamux_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 59,
  parameter int TRIG_CH = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CFG_W-1:0]   bus_wdata,
  output logic [CFG_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic [NUM_SRC-1:0] src_ack,
  input  logic [TRIG_CH-1:0] trig_in,
  output logic [NUM_CH-1:0]  ch_req,
  input  logic [NUM_CH-1:0]  ch_ack
);

  chan_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]      wr_hit;
  logic [NUM_CH-1:0]      gate_open;
  logic [NUM_CH-1:0]      armed;

  // Flattened views of the configuration for the bound checker.
  logic [NUM_CH-1:0]       cfg_en;
  logic [NUM_CH-1:0]       cfg_trig;
  logic [NUM_CH*SEL_W-1:0] cfg_sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign cfg_en[c]                 = cfg[c].en;
    assign cfg_trig[c]               = cfg[c].trig;
    assign cfg_sel[c*SEL_W +: SEL_W] = cfg[c].sel;
  end

  dmamux_cfg_regs #(
    .NUM_CH (NUM_CH),
    .TRIG_CH(TRIG_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cfg_o    (cfg),
    .wr_hit   (wr_hit)
  );

  dmamux_trig_gate #(
    .NUM_CH (NUM_CH),
    .TRIG_CH(TRIG_CH)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .cfg      (cfg),
    .wr_hit   (wr_hit),
    .ch_ack   (ch_ack),
    .gate_open(gate_open),
    .armed_o  (armed)
  );

  dmamux_route #(
    .NUM_CH (NUM_CH),
    .NUM_SRC(NUM_SRC)
  ) u_route (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .gate_open(gate_open),
    .src_req  (src_req),
    .ch_ack   (ch_ack),
    .ch_req   (ch_req),
    .src_ack  (src_ack)
  );

endmodule

// File: rtl/dmamux_checker.sv
module dmamux_checker
  import dmamux_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int NUM_SRC = 59,
  parameter int TRIG_CH = 8,
  parameter int ADDR_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [CFG_W-1:0]        bus_rdata,
  input logic [NUM_SRC-1:0]      src_req,
  input logic [NUM_SRC-1:0]      src_ack,
  input logic [NUM_CH-1:0]       ch_req,
  input logic [NUM_CH-1:0]       ch_ack,
  input logic [NUM_CH-1:0]       cfg_en,
  input logic [NUM_CH-1:0]       cfg_trig,
  input logic [NUM_CH*SEL_W-1:0] cfg_sel,
  input logic [NUM_CH-1:0]       armed
);

  // R8: an acknowledge to a source follows some channel acknowledge.
  p_ack_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (|src_ack) |-> $past(|ch_ack));

  // R6: the trigger bit of a high channel never reads back as 1.
  p_high_trig_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) >= ADDR_W'(TRIG_CH)) |-> !bus_rdata[TRIG_BIT]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R3: a request needs the channel enabled in the previous cycle.
    p_disabled_low_r3: assert property (@(posedge clk) disable iff (rst)
      ch_req[c] |-> $past(cfg_en[c]));

    // R7: a request needs a valid source number in the previous cycle.
    p_no_source_no_req_r7: assert property (@(posedge clk) disable iff (rst)
      ch_req[c] |-> ($past(cfg_sel[c*SEL_W +: SEL_W]) < SEL_W'(NUM_SRC)));

    // R4: a request needs some source request in the previous cycle.
    p_req_has_source_r4: assert property (@(posedge clk) disable iff (rst)
      ch_req[c] |-> $past(|src_req));

    if (c < TRIG_CH) begin : g_low
      // R5: in trigger mode a request needs the arm held in the previous cycle.
      p_gated_needs_arm_r5: assert property (@(posedge clk) disable iff (rst)
        (ch_req[c] && $past(cfg_trig[c])) |-> $past(armed[c]));

      // R9: a register write leaves the channel disarmed.
      p_write_disarms_r9: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && (bus_addr == ADDR_W'(c))) |-> !armed[c]);
    end
  end

endmodule

bind dmamux_top dmamux_checker #(
  .NUM_CH (NUM_CH),
  .NUM_SRC(NUM_SRC),
  .TRIG_CH(TRIG_CH),
  .ADDR_W (ADDR_W)
) u_dmamux_checker (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .src_req  (src_req),
  .src_ack  (src_ack),
  .ch_req   (ch_req),
  .ch_ack   (ch_ack),
  .cfg_en   (cfg_en),
  .cfg_trig (cfg_trig),
  .cfg_sel  (cfg_sel),
  .armed    (armed)
);

// File: tb/test_dmamux_top.sv
module test_dmamux_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 32;
  localparam int NSRC = 59;
  localparam int NTRG = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic [NSRC-1:0] src_req = '0;
  logic [NSRC-1:0] src_ack;
  logic [NTRG-1:0] trig_in = '0;
  logic [NCH-1:0]  ch_req;
  logic [NCH-1:0]  ch_ack = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmamux_top i_dmamux_top (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
    .src_ack(src_ack), .trig_in(trig_in), .ch_req(ch_req), .ch_ack(ch_ack)
  );

  // ---------------- reference model ----------------
  bit    m_en[NCH];
  bit    m_trig[NCH];
  int    m_sel[NCH];
  bit    m_arm[NTRG];
  bit    m_tq[NTRG];
  logic [NCH-1:0]  e_req = '0;
  logic [NSRC-1:0] e_ack = '0;
  logic [7:0]      e_rd  = '0;
  string           e_tag[NCH];
  string           e_rdtag = "R1";
  string           e_acktag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_trig[c] = 0; m_sel[c] = 0; e_tag[c] = "R1";
      end
      for (int c = 0; c < NTRG; c++) begin m_arm[c] = 0; m_tq[c] = 0; end
      e_req = '0; e_ack = '0; e_rd = '0; e_rdtag = "R1"; e_acktag = "R1";
    end else begin
      int a;
      a = int'(bus_addr);
      if (a < NCH) begin
        e_rd = {m_en[a], m_trig[a], 6'(m_sel[a])};
        e_rdtag = (a >= NTRG) ? "R6" : "R2";
      end else begin
        e_rd = 8'h00;
        e_rdtag = "R2";
      end
      for (int c = 0; c < NCH; c++) begin
        bit open;
        open = !m_trig[c] || (c < NTRG && m_arm[c]);
        e_req[c] = m_en[c] && (m_sel[c] < NSRC) && open && src_req[m_sel[c] % NSRC];
        if (!m_en[c])            e_tag[c] = "R3";
        else if (m_sel[c] >= NSRC) e_tag[c] = "R7";
        else if (m_trig[c])      e_tag[c] = "R5";
        else                     e_tag[c] = (c >= NTRG) ? "R6" : "R4";
      end
      e_ack = '0;
      for (int c = 0; c < NCH; c++)
        if (m_en[c] && ch_ack[c] && m_sel[c] < NSRC) e_ack[m_sel[c]] = 1'b1;
      e_acktag = "R8";
      for (int c = 0; c < NTRG; c++) begin
        bit rise;
        rise = trig_in[c] && !m_tq[c];
        if (bus_we && a == c)                  m_arm[c] = 0;
        else if (rise && m_en[c] && m_trig[c]) m_arm[c] = 1;
        else if (ch_ack[c])                    m_arm[c] = 0;
        m_tq[c] = trig_in[c];
      end
      if (bus_we && a < NCH) begin
        m_en[a]   = bus_wdata[7];
        m_trig[a] = (a < NTRG) ? bus_wdata[6] : 1'b0;
        m_sel[a]  = int'(bus_wdata[5:0]);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Comparison against the model on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++)
        check(ch_req[c] === e_req[c], e_tag[c], $sformatf("ch_req[%0d]", c),
              64'(ch_req[c]), 64'(e_req[c]));
      check(src_ack === e_ack, e_acktag, "src_ack", 64'(src_ack), 64'(e_ack));
      check(bus_rdata === e_rd, e_rdtag, "bus_rdata", 64'(bus_rdata), 64'(e_rd));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    bus_we = 1'b1; bus_addr = 8'(addr); bus_wdata = data;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd_expect(input int addr, input logic [7:0] exp, input string tag);
    bus_addr = 8'(addr);
    step();
    @(negedge clk);
    check(bus_rdata === exp, tag, $sformatf("read addr %0d", addr), 64'(bus_rdata), 64'(exp));
    #1;
  endtask

  task automatic finish_report();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_report();
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) step();
    @(negedge clk);
    check(ch_req === '0 && src_ack === '0 && bus_rdata === '0, "R1",
          "outputs in reset", 64'(ch_req), 64'd0);
    #1;
    rst = 1'b0;
    // R1: every register reads zero after reset
    for (int c = 0; c < NCH; c += 7) rd_expect(c, 8'h00, "R1");

    // R2 / R4: channel 0 transparent on source 5
    wr(0, 8'h85);
    rd_expect(0, 8'h85, "R2");
    src_req[5] = 1'b1; step(); step();
    @(negedge clk);
    check(ch_req[0] === 1'b1, "R4", "transparent request", 64'(ch_req[0]), 64'd1);
    #1;
    src_req[5] = 1'b0; step(); step();

    // R3: channel 1 disabled but pointed at an active source
    wr(1, 8'h45);
    src_req[5] = 1'b1; step(); step();
    @(negedge clk);
    check(ch_req[1] === 1'b0, "R3", "disabled channel", 64'(ch_req[1]), 64'd0);
    #1;

    // R7: channel 2 on an unused source number
    wr(2, 8'h80 | 8'd60);
    src_req = '1; step(); step();
    @(negedge clk);
    check(ch_req[2] === 1'b0, "R7", "unused source", 64'(ch_req[2]), 64'd0);
    #1;
    src_req = '0;

    // R5: channel 3 trigger mode on source 7
    wr(3, 8'hC7);
    src_req[7] = 1'b1; step(); step();
    @(negedge clk);
    check(ch_req[3] === 1'b0, "R5", "not yet armed", 64'(ch_req[3]), 64'd0);
    #1;
    trig_in[3] = 1'b1; step(); trig_in[3] = 1'b0; step();
    @(negedge clk);
    check(ch_req[3] === 1'b1, "R5", "armed forwards", 64'(ch_req[3]), 64'd1);
    #1;
    ch_ack[3] = 1'b1; step(); ch_ack[3] = 1'b0; step();
    @(negedge clk);
    check(ch_req[3] === 1'b0, "R5", "ack disarms", 64'(ch_req[3]), 64'd0);
    #1;
    src_req[7] = 1'b0;

    // R9: rewriting the same value clears a pending arm
    wr(4, 8'hCB);
    trig_in[4] = 1'b1; step(); trig_in[4] = 1'b0; step();
    wr(4, 8'hCB);
    src_req[11] = 1'b1; step(); step(); step();
    @(negedge clk);
    check(ch_req[4] === 1'b0, "R9", "write clears arm", 64'(ch_req[4]), 64'd0);
    #1;
    src_req[11] = 1'b0;

    // R6: trigger bit dropped on a high channel, which then acts transparent
    wr(9, 8'hCA);
    rd_expect(9, 8'h8A, "R6");
    src_req[10] = 1'b1; step(); step();
    @(negedge clk);
    check(ch_req[9] === 1'b1, "R6", "high channel ignores trigger", 64'(ch_req[9]), 64'd1);
    #1;
    src_req[10] = 1'b0;

    // R8: acknowledge returns to the selected source only
    ch_ack[0] = 1'b1; ch_ack[1] = 1'b1; step(); ch_ack = '0;
    @(negedge clk);
    check(src_ack === (NSRC'(1) << 5), "R8", "ack routing", 64'(src_ack), 64'(NSRC'(1) << 5));
    #1;

    // R2: unmapped address ignores writes and reads zero
    wr(40, 8'hFF);
    rd_expect(40, 8'h00, "R2");

    // Random phase, compared against the model every cycle.
    for (int i = 0; i < 4000; i++) begin
      bus_we    = ($urandom_range(3) == 0);
      bus_addr  = 8'($urandom_range(35));
      bus_wdata = 8'($urandom());
      src_req   = NSRC'({$urandom(), $urandom()});
      trig_in   = 8'($urandom()) & 8'($urandom());
      ch_ack    = $urandom() & $urandom();
      step();
    end
    bus_we = 1'b0; ch_ack = '0;
    step(); step();
    @(negedge clk);
    #1;
    finish_report();
  end

endmodule